// File: doc/BRIEF.md
# LPC Host I/O Cycle Engine

This block is the host side of a Low Pin Count bus, limited to I/O reads and writes. A processor-side requester presents an address, a direction, a size of one, two or four bytes and write data, and holds `req_valid` high. The engine runs one byte-wide LPC I/O cycle per byte, starting at the lowest address and stepping to consecutive addresses. When the last byte cycle has ended, it raises `req_ready` for one clock and presents the assembled read data and status. The requester drops `req_valid` in the clock in which it sees `req_ready`.

Each byte cycle has a fixed order. First come the framing nibble, the cycle-type nibble and four address nibbles, then write data if the cycle is a write. A turn-around follows. The engine then watches the peripheral's SYNC nibble. Wait codes extend the cycle. A ready or error code completes it. A silent bus or an undefined code makes the engine abort: it holds the frame line low and drives all-ones. Bytes of an aborted read come back as FFh, so the requester sees the same value a bus with pull-ups gives when nobody answers.

The pins `lad_out`, `lad_oe` and `lframe_n` are decoded from the registered state. `lad_in` is sampled on the rising clock edge.

Top module: `lpc_io_host`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `lframe_n` is 1, `lad_oe` is 0 and `req_ready` is 0.
- R2: Each byte cycle begins with exactly one clock of `lframe_n`=0 and `lad_out`=0000b. The next clock has `lframe_n`=1 and a cycle-type nibble of 0000b for a read or 0010b for a write, with `lad_oe`=1.
- R3: After the cycle-type nibble, the 16-bit byte address is driven over four clocks, most significant nibble first.
- R4: A write sends its data byte over two clocks, low nibble first. Every cycle then drives 1111b with `lad_oe`=1 for one clock, and releases the bus (`lad_oe`=0) for one clock.
- R5: `req_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3). Byte i uses address `req_addr`+i, wrapping at 16 bits, with the lowest address first. A write sends byte i from `req_wdata[8i+7:8i]`.
- R6: `req_ready` is high for exactly one clock per request, after the last byte cycle. With every byte answered at once, a byte takes 13 clocks. The pulse comes one clock after the sum of the byte times, counted from the first clock after acceptance.
- R7: SYNC 0000b completes the cycle. A read then captures two data nibbles, low first, into `rsp_rdata[8i+7:8i]` for byte i. Bytes beyond the request size, and all of `rsp_rdata` on a write, read as zero.
- R8: SYNC 0101b or 0110b holds the engine in SYNC for one more clock and clears the no-response count.
- R9: Four consecutive SYNC clocks of 1111b abort the byte cycle.
- R10: Any SYNC nibble other than 0000b, 0101b, 0110b, 1010b or 1111b aborts the byte cycle on the clock it is seen.
- R11: An abort drives `lframe_n`=0 and `lad_out`=1111b with `lad_oe`=1 for four clocks, then leaves the bus idle for one clock. It sets `rsp_abort`, and on a read the byte returns FFh. Any remaining bytes are still run.
- R12: SYNC 1010b completes the byte like 0000b, including the read data, and sets `rsp_error`.
- R13: The request fields are captured when the request is accepted. Changes on them before `req_ready` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_write | input | 1 | 1 = I/O write, 0 = I/O read |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_addr | input | 16 | Lowest I/O byte address |
| req_wdata | input | 32 | Write data, byte i in bits 8i+7:8i |
| req_ready | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `req_ready` |
| rsp_error | output | 1 | Some byte ended with the error SYNC |
| rsp_abort | output | 1 | Some byte was aborted |
| lframe_n | output | 1 | Frame line, active low |
| lad_out | output | 4 | Nibble driven onto the shared bus |
| lad_oe | output | 1 | Drive enable for `lad_out` |
| lad_in | input | 4 | Nibble sampled from the shared bus |

## Verification
Every pin value is a decode of the state register, so a bus phase shows up one clock after the edge that enters it. The peripheral model answers in that same clock, and the engine samples the answer on the next rising edge.

The bench predicts the completion clock of each request from the per-byte costs, where n is the number of wait nibbles:
- a normal read or write takes 13 + n clocks;
- a timed-out byte takes 17 + n clocks on a read and 19 + n on a write;
- a byte rejected for a bad code takes 14 + n clocks on a read and 16 + n on a write;
- one more clock is added for the completion state.

It counts falling edges from the drive of `req_valid` to the first falling edge with `req_ready` high, and compares that count exactly. All pins and responses are read on falling edges, half a period away from the edge that changes them.

// File: rtl/lpc_io_pkg.sv
`timescale 1ns/1ps
package lpc_io_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_CYC, ST_ADDR, ST_WDATA, ST_TAR,
        ST_SYNC, ST_RDATA, ST_TARB, ST_ABORT, ST_GAP, ST_DONE
    } lpc_state_e;

    typedef enum logic [2:0] {
        SC_READY, SC_WAIT, SC_ERROR, SC_NONE, SC_BAD
    } sync_class_e;

    localparam logic [3:0] NIB_FRAME   = 4'b0000;
    localparam logic [3:0] NIB_IO_RD   = 4'b0000;
    localparam logic [3:0] NIB_IO_WR   = 4'b0010;
    localparam logic [3:0] NIB_ONES    = 4'b1111;
    localparam logic [3:0] SYNC_OK     = 4'b0000;
    localparam logic [3:0] SYNC_SHORT  = 4'b0101;
    localparam logic [3:0] SYNC_LONG   = 4'b0110;
    localparam logic [3:0] SYNC_FAULT  = 4'b1010;

endpackage

// File: rtl/lpc_sync_class.sv
`timescale 1ns/1ps
module lpc_sync_class
    import lpc_io_pkg::*;
(
    input  logic [3:0]  nib,
    output sync_class_e cls
);

    always_comb begin
        unique case (nib)
            SYNC_OK:            cls = SC_READY;
            SYNC_SHORT,
            SYNC_LONG:          cls = SC_WAIT;
            SYNC_FAULT:         cls = SC_ERROR;
            NIB_ONES:           cls = SC_NONE;
            default:            cls = SC_BAD;
        endcase
    end

endmodule

// File: rtl/lpc_sync_timer.sv
`timescale 1ns/1ps
module lpc_sync_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic silent,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (active && silent) begin
            cnt_d = cnt_q + CW'(1);
        end else begin
            cnt_d = '0;
        end
        expired = active && silent && (cnt_q == CW'(LIMIT - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lpc_pin_drive.sv
`timescale 1ns/1ps
module lpc_pin_drive
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 2
) (
    input  lpc_state_e        st,
    input  logic [CNT_W-1:0]  nib,
    input  logic              is_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    output logic              frame_n,
    output logic [3:0]        lad,
    output logic              oe
);

    localparam int NIBS = ADDR_W / 4;

    logic [ADDR_W-1:0] addr_sh;

    always_comb begin
        addr_sh = addr >> (4 * (NIBS - 1 - int'(nib)));
        frame_n = 1'b1;
        lad     = NIB_ONES;
        oe      = 1'b0;
        unique case (st)
            ST_START: begin
                frame_n = 1'b0;
                lad     = NIB_FRAME;
                oe      = 1'b1;
            end
            ST_CYC: begin
                lad = is_write ? NIB_IO_WR : NIB_IO_RD;
                oe  = 1'b1;
            end
            ST_ADDR: begin
                lad = addr_sh[3:0];
                oe  = 1'b1;
            end
            ST_WDATA: begin
                lad = (nib == '0) ? wbyte[3:0] : wbyte[7:4];
                oe  = 1'b1;
            end
            ST_TAR: begin
                lad = NIB_ONES;
                oe  = (nib == '0);
            end
            ST_ABORT: begin
                frame_n = 1'b0;
                lad     = NIB_ONES;
                oe      = 1'b1;
            end
            default: begin
                frame_n = 1'b1;
                lad     = NIB_ONES;
                oe      = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lpc_io_host.sv
`timescale 1ns/1ps
module lpc_io_host
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 32,
    parameter int SYNC_LIMIT   = 4,
    parameter int ABORT_CLKS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_error,
    output logic              rsp_abort,
    output logic              lframe_n,
    output logic [3:0]        lad_out,
    output logic              lad_oe,
    input  logic [3:0]        lad_in
);

    localparam int NIBS      = ADDR_W / 4;
    localparam int MAX_BYTES = DATA_W / 8;
    localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam int CNT_MAX   = (NIBS > ABORT_CLKS) ? ((NIBS > 2) ? NIBS : 2)
                                                   : ((ABORT_CLKS > 2) ? ABORT_CLKS : 2);
    localparam int CNT_W     = $clog2(CNT_MAX);

    typedef struct packed {
        lpc_state_e        st;
        logic [CNT_W-1:0]  nib;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              err;
        logic              abrt;
    } regs_t;

    regs_t d, q;

    sync_class_e       cls;
    logic              tmo;
    logic [IDX_W-1:0]  last_req;
    logic [ADDR_W-1:0] addr_cur;
    logic [7:0]        wbyte_cur;
    logic              is_last;

    lpc_sync_class u_cls (
        .nib (lad_in),
        .cls (cls)
    );

    lpc_sync_timer #(.LIMIT(SYNC_LIMIT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (q.st == ST_SYNC),
        .silent  (cls == SC_NONE),
        .expired (tmo)
    );

    lpc_pin_drive #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pins (
        .st       (q.st),
        .nib      (q.nib),
        .is_write (q.wr),
        .addr     (addr_cur),
        .wbyte    (wbyte_cur),
        .frame_n  (lframe_n),
        .lad      (lad_out),
        .oe       (lad_oe)
    );

    // size code to index of the final byte, clamped to the data width
    always_comb begin
        int nb;
        nb = 1 << req_size;
        if (req_size == 2'd3) begin
            nb = 4;
        end
        if (nb > MAX_BYTES) begin
            nb = MAX_BYTES;
        end
        last_req = IDX_W'(nb - 1);
    end

    assign addr_cur  = q.base + ADDR_W'(q.idx);
    assign wbyte_cur = q.wdat[8*q.idx +: 8];
    assign is_last   = (q.idx == q.last);

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st   = ST_START;
                    d.wr   = req_write;
                    d.base = req_addr;
                    d.wdat = req_wdata;
                    d.rdat = '0;
                    d.err  = 1'b0;
                    d.abrt = 1'b0;
                    d.idx  = '0;
                    d.last = last_req;
                    d.nib  = '0;
                end
            end
            ST_START: begin
                d.st = ST_CYC;
            end
            ST_CYC: begin
                d.st  = ST_ADDR;
                d.nib = '0;
            end
            ST_ADDR: begin
                if (q.nib == CNT_W'(NIBS - 1)) begin
                    d.nib = '0;
                    d.st  = q.wr ? ST_WDATA : ST_TAR;
                end else begin
                    d.nib = q.nib + CNT_W'(1);
                end
            end
            ST_WDATA: begin
                if (q.nib == CNT_W'(1)) begin
                    d.nib = '0;
                    d.st  = ST_TAR;
                end else begin
                    d.nib = q.nib + CNT_W'(1);
                end
            end
            ST_TAR: begin
                if (q.nib == CNT_W'(1)) begin
                    d.nib = '0;
                    d.st  = ST_SYNC;
                end else begin
                    d.nib = q.nib + CNT_W'(1);
                end
            end
            ST_SYNC: begin
                unique case (cls)
                    SC_READY, SC_ERROR: begin
                        if (cls == SC_ERROR) begin
                            d.err = 1'b1;
                        end
                        d.nib = '0;
                        d.st  = q.wr ? ST_TARB : ST_RDATA;
                    end
                    SC_WAIT: begin
                        d.st = ST_SYNC;
                    end
                    SC_NONE: begin
                        if (tmo) begin
                            d.st   = ST_ABORT;
                            d.nib  = '0;
                            d.abrt = 1'b1;
                            if (!q.wr) begin
                                d.rdat[8*q.idx +: 8] = 8'hFF;
                            end
                        end
                    end
                    default: begin
                        d.st   = ST_ABORT;
                        d.nib  = '0;
                        d.abrt = 1'b1;
                        if (!q.wr) begin
                            d.rdat[8*q.idx +: 8] = 8'hFF;
                        end
                    end
                endcase
            end
            ST_RDATA: begin
                if (q.nib == '0) begin
                    d.rdat[8*q.idx +: 4] = lad_in;
                    d.nib = CNT_W'(1);
                end else begin
                    d.rdat[8*q.idx + 4 +: 4] = lad_in;
                    d.nib = '0;
                    d.st  = ST_TARB;
                end
            end
            ST_TARB: begin
                if (q.nib == CNT_W'(1)) begin
                    d.nib = '0;
                    if (is_last) begin
                        d.st = ST_DONE;
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                        d.st  = ST_START;
                    end
                end else begin
                    d.nib = q.nib + CNT_W'(1);
                end
            end
            ST_ABORT: begin
                if (q.nib == CNT_W'(ABORT_CLKS - 1)) begin
                    d.nib = '0;
                    d.st  = ST_GAP;
                end else begin
                    d.nib = q.nib + CNT_W'(1);
                end
            end
            ST_GAP: begin
                if (is_last) begin
                    d.st = ST_DONE;
                end else begin
                    d.idx = q.idx + IDX_W'(1);
                    d.st  = ST_START;
                end
            end
            ST_DONE: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_DONE);
    assign rsp_rdata = q.rdat;
    assign rsp_error = q.err;
    assign rsp_abort = q.abrt;

endmodule

// File: rtl/lpc_io_host_chk.sv
`timescale 1ns/1ps
module lpc_io_host_chk #(
    parameter int ABORT_MIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       lframe_n,
    input logic       lad_oe,
    input logic [3:0] lad_out
);

    logic [7:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!lframe_n && lad_out == 4'hF) begin
            run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
        end else begin
            run_q <= '0;
        end
    end

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);                                          // R6

    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (lframe_n && !lad_oe));                                // R6

    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (!lframe_n && lad_out == 4'h0) |=> lframe_n);                        // R2

    AST_FRAME_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |-> lad_oe);                                               // R11

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lframe_n) && $past(lad_out) == 4'hF) |-> (run_q >= 8'(ABORT_MIN))); // R11

endmodule

bind lpc_io_host lpc_io_host_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .lframe_n  (lframe_n),
    .lad_oe    (lad_oe),
    .lad_out   (lad_out)
);

// File: tb/sim_lpc_io_host.sv
`timescale 1ns/1ps
module sim_lpc_io_host;

    typedef struct packed {
        logic        wr;
        logic [1:0]  size;
        logic [15:0] addr;
        logic [31:0] wdata;
        logic [3:0]  nwait;
        logic [3:0]  code;
        logic [3:0]  mask;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 16'h0060, 32'h0000_0000, 4'd0, 4'h0, 4'h0}, // R2 R3 R7 read byte
        '{1'b1, 2'd0, 16'h0080, 32'h0000_00A5, 4'd0, 4'h0, 4'h0}, // R4 write byte
        '{1'b0, 2'd1, 16'h03F8, 32'h0000_0000, 4'd0, 4'h0, 4'h0}, // R5 read 16
        '{1'b1, 2'd2, 16'h0CF8, 32'h8000_1234, 4'd0, 4'h0, 4'h0}, // R5 write 32
        '{1'b0, 2'd0, 16'h0070, 32'h0000_0000, 4'd3, 4'h0, 4'h0}, // R8 waits
        '{1'b0, 2'd2, 16'h0100, 32'h0000_0000, 4'd0, 4'hF, 4'h4}, // R9 R11 timeout byte 2
        '{1'b1, 2'd1, 16'h0200, 32'h0000_BEEF, 4'd0, 4'h3, 4'h1}, // R10 bad code
        '{1'b0, 2'd0, 16'h0064, 32'h0000_0000, 4'd2, 4'hA, 4'h1}, // R12 error sync
        '{1'b0, 2'd0, 16'h0061, 32'h0000_0000, 4'd2, 4'hF, 4'h1}, // R8 R9 wait then silent
        '{1'b0, 2'd3, 16'hFFFE, 32'h0000_0000, 4'd1, 4'h0, 4'h0}, // R5 wrap, size 3
        '{1'b1, 2'd0, 16'h0090, 32'h0000_005A, 4'd0, 4'hF, 4'h1}  // R9 R11 write timeout
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready;
    logic [31:0] rsp_rdata;
    logic        rsp_error;
    logic        rsp_abort;
    logic        lframe_n;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [3:0]  lad_in = 4'hF;

    always #2.5 clk = ~clk;

    lpc_io_host u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .rsp_rdata (rsp_rdata),
        .rsp_error (rsp_error),
        .rsp_abort (rsp_abort),
        .lframe_n  (lframe_n),
        .lad_out   (lad_out),
        .lad_oe    (lad_oe),
        .lad_in    (lad_in)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // script of the current request, read by the peripheral model
    logic        cur_wr = 1'b0;
    logic [15:0] cur_addr = '0;
    logic [31:0] cur_wdata = '0;
    int          cur_nwait = 0;
    logic [3:0]  cur_code = 4'h0;
    logic [3:0]  cur_mask = 4'h0;

    int          pk = -1;
    int          p_byte = 0;
    int          starts = 0;
    int          abort_runs = 0;
    int          abort_badlen = 0;
    int          low_run = 0;
    int          ready_cnt = 0;
    logic [15:0] p_addr = '0;
    logic [7:0]  p_wd = '0;

    always @(negedge clk) begin
        if (req_ready) begin
            ready_cnt++;
        end
    end

    // peripheral model: reacts in the clock the host shows a phase
    always @(negedge clk) begin
        lad_in = 4'hF;
        if (!rst_n) begin
            pk = -1;
            low_run = 0;
        end else if (!lframe_n && lad_out == 4'h0) begin
            pk = 0;
            p_byte = starts;
            starts++;
        end else if (!lframe_n) begin
            pk = -1;
            low_run++;
        end else begin
            if (low_run > 0) begin
                abort_runs++;
                if (low_run != 4) begin
                    abort_badlen++;
                end
                low_run = 0;
            end
            if (pk >= 0) begin
                int tk;
                int sk;
                int j;
                logic [3:0] c;
                logic [15:0] ba;
                pk++;
                tk = cur_wr ? 8 : 6;
                sk = tk + 2;
                ba = cur_addr + 16'(p_byte);
                c  = cur_mask[p_byte] ? cur_code : 4'h0;
                if (pk == 1) begin
                    chk(lad_oe && lad_out == (cur_wr ? 4'h2 : 4'h0), "R2 cycle type",
                        {27'd0, lad_oe, lad_out}, {27'd0, 1'b1, (cur_wr ? 4'h2 : 4'h0)});
                end else if (pk >= 2 && pk <= 5) begin
                    p_addr = {p_addr[11:0], lad_out};
                    if (pk == 5) begin
                        chk(p_addr == ba, "R3 R5 address", {16'd0, p_addr}, {16'd0, ba});
                    end
                end else if (cur_wr && pk == 6) begin
                    p_wd[3:0] = lad_out;
                end else if (cur_wr && pk == 7) begin
                    p_wd[7:4] = lad_out;
                    chk(p_wd == cur_wdata[8*p_byte +: 8], "R4 R5 write byte",
                        {24'd0, p_wd}, {24'd0, cur_wdata[8*p_byte +: 8]});
                end else if (pk == tk) begin
                    chk(lad_oe && lad_out == 4'hF, "R4 turn-around drive",
                        {27'd0, lad_oe, lad_out}, 32'h1F);
                end else if (pk == tk + 1) begin
                    chk(!lad_oe, "R4 turn-around release", {31'd0, lad_oe}, 32'd0);
                end else if (pk >= sk) begin
                    j = pk - sk;
                    if (j < cur_nwait) begin
                        lad_in = j[0] ? 4'h6 : 4'h5;
                    end else if (j == cur_nwait) begin
                        lad_in = c;
                    end else if (c == 4'hF) begin
                        lad_in = 4'hF;
                    end else if (!cur_wr && (c == 4'h0 || c == 4'hA) && j == cur_nwait + 1) begin
                        lad_in = pat(ba)[3:0];
                    end else if (!cur_wr && (c == 4'h0 || c == 4'hA) && j == cur_nwait + 2) begin
                        lad_in = pat(ba)[7:4];
                    end
                end
            end
        end
    end

    task automatic run_req(input vec_t v, input bool_chg);
    endtask

    int lat;

    task automatic do_req(input vec_t v, input bit disturb);
        int          n;
        int          exp_lat;
        int          runs;
        logic [31:0] exp_rd;
        bit          exp_err;
        bit          exp_ab;
        n = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
        exp_lat = 1;
        runs = 0;
        exp_rd = '0;
        exp_err = 1'b0;
        exp_ab = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [3:0] c;
            int base;
            bit ab;
            c = v.mask[i] ? v.code : 4'h0;
            base = v.wr ? 10 : 8;
            ab = !(c == 4'h0 || c == 4'hA);
            if (c == 4'hF) begin
                exp_lat += base + int'(v.nwait) + 9;
            end else if (ab) begin
                exp_lat += base + int'(v.nwait) + 6;
            end else begin
                exp_lat += base + int'(v.nwait) + 3 + (v.wr ? 0 : 2);
            end
            if (ab) begin
                exp_ab = 1'b1;
                runs++;
            end
            if (c == 4'hA) begin
                exp_err = 1'b1;
            end
            if (!v.wr) begin
                exp_rd[8*i +: 8] = ab ? 8'hFF : pat(v.addr + 16'(i));
            end
        end
        @(negedge clk);
        cur_wr = v.wr;
        cur_addr = v.addr;
        cur_wdata = v.wdata;
        cur_nwait = int'(v.nwait);
        cur_code = v.code;
        cur_mask = v.mask;
        starts = 0;
        abort_runs = 0;
        abort_badlen = 0;
        ready_cnt = 0;
        req_valid = 1'b1;
        req_write = v.wr;
        req_size = v.size;
        req_addr = v.addr;
        req_wdata = v.wdata;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (disturb && lat == 3) begin
                // R13: new field values while the request is in flight
                req_write = ~v.wr;
                req_size = 2'd0;
                req_addr = v.addr ^ 16'h5555;
                req_wdata = ~v.wdata;
            end
        end while (!req_ready && lat < 1000);
        req_valid = 1'b0;
        chk(req_ready == 1'b1, "R6 completion", {31'd0, req_ready}, 32'd1);
        chk(lat == exp_lat, "R6 latency", lat, exp_lat);
        chk(rsp_rdata == exp_rd, v.wr ? "R7 write returns zero" : "R7 R11 read data", rsp_rdata, exp_rd);
        chk(rsp_error == exp_err, "R12 error flag", {31'd0, rsp_error}, {31'd0, exp_err});
        chk(rsp_abort == exp_ab, "R9 R10 abort flag", {31'd0, rsp_abort}, {31'd0, exp_ab});
        repeat (3) @(negedge clk);
        chk(ready_cnt == 1, "R6 single pulse", ready_cnt, 1);
        chk(starts == n, "R5 byte cycles", starts, n);
        chk(abort_runs == runs && abort_badlen == 0, "R11 abort frames",
            abort_runs * 256 + abort_badlen, runs * 256);
        chk(lframe_n && !lad_oe, "R1 bus idle after request",
            {30'd0, lframe_n, lad_oe}, 32'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(lframe_n && !lad_oe && !req_ready, "R1 in reset",
            {29'd0, lframe_n, lad_oe, req_ready}, 32'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(lframe_n && !lad_oe && !req_ready, "R1 after reset",
            {29'd0, lframe_n, lad_oe, req_ready}, 32'h4);

        for (int k = 0; k < NVEC; k++) begin
            do_req(VEC[k], 1'b0);
        end

        // R13: fields changed mid-request are ignored
        do_req('{1'b0, 2'd1, 16'h0042, 32'h0, 4'd0, 4'h0, 4'h0}, 1'b1);
        do_req('{1'b1, 2'd2, 16'h0300, 32'h1122_3344, 4'd1, 4'h0, 4'h0}, 1'b1);

        // R1: reset during a cycle returns the bus to idle
        @(negedge clk);
        cur_wr = 1'b0;
        cur_addr = 16'h0050;
        cur_nwait = 0;
        cur_code = 4'h0;
        cur_mask = 4'h0;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_size = 2'd2;
        req_addr = 16'h0050;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(negedge clk);
        chk(lframe_n && !lad_oe && !req_ready, "R1 reset mid-cycle",
            {29'd0, lframe_n, lad_oe, req_ready}, 32'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(lframe_n && !lad_oe && !req_ready, "R1 idle after mid-cycle reset",
            {29'd0, lframe_n, lad_oe, req_ready}, 32'h4);
        do_req(VEC[0], 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule